// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Sticky Status Flags

This block is a byte-wide serial peripheral port for a small processor bus. It runs either as the clock-driving side of the link or as the clock-following side. It moves 8-bit frames, most significant bit first, through one shift register, and it holds the last received byte in a single-entry buffer. Software uses two byte-wide locations: a control/status word and a data location. Writing the data location loads the next outgoing byte. In master operation that write also starts the frame. Reading the data location returns the buffered byte and marks it consumed.

Four event flags record frame completion, a data write during a frame, a select conflict while driving the clock, and a frame finishing into an unread buffer. Hardware sets each of these flags, and only software clears it. The interrupt request is high while any of the four is set. A busy bit follows the master frame. A select bit follows the select pin after two-stage synchronization. In slave operation the select, clock and data pins are resampled into the system clock domain before they are used.

Top module: `spi_ss_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x00 while the select pin is high, and the interrupt request is low.
- R2: With bus_sel=0 the bus reads the control/status word, laid out from bit 7 down as done, collision, mode-fault, overrun, busy, selected, master, enable. With bus_sel=1 the bus reads the receive buffer. A control write stores bits 1:0 (master, enable) as written.
- R3: A control write clears each of bits 7:4 that it writes as 0, and leaves set any that it writes as 1. It never sets them. Writes to bits 3:2 have no effect. If a hardware set and a clearing write reach the same flag in the same cycle, the flag is set.
- R4: With enable and master both 1 and busy 0, a data write starts a frame. Busy reads 1 from the next cycle and stays 1 for 8*CLK_DIV cycles. sck_o idles low and toggles every CLK_DIV/2 cycles. When the frame ends, busy drops and done is set, and done stays set until software clears it.
- R5: The master samples miso_i on each rising sck_o edge, most significant bit first, and the received byte appears in the receive buffer at the end of the frame.
- R6: A data write while a frame is in progress (master busy, or slave mid-frame) sets the collision flag and is discarded. The frame in progress completes with its original byte.
- R7: While enable and master are both 1 and the synchronized select is low, the mode-fault flag is set every cycle.
- R8: A frame that completes while the buffer still holds an unread byte sets the overrun flag, and the older byte is kept. A data read marks the buffer as consumed.
- R9: The selected bit reads as the inverse of nss_i, delayed by two clock cycles.
- R10: With enable 1 and master 0, while the synchronized select is low, each synchronized rising edge on sck_i shifts mosi_i in, most significant bit first. The eighth edge sets done and fills the buffer. miso_o presents the top bit of the shift register, which a data write loads between frames.
- R11: irq is 1 exactly when at least one of bits 7:4 is set.
- R12: With enable 0, data writes start nothing and set no flag. Clearing enable or master during a master frame ends it at once: busy 0, sck_o low, done not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects control/status, 1 selects data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a data read marks the buffer as consumed) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master operation |
| mosi_o | output | 1 | Serial data out in master operation |
| miso_i | input | 1 | Serial data in for master operation |
| sck_i | input | 1 | Serial clock in for slave operation |
| mosi_i | input | 1 | Serial data in for slave operation |
| nss_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out in slave operation |

## Verification
A wrong frame counter or clock divider shows up on sck_o or the busy bit within one half-period, because both are compared to the expected value on every clock. A corrupted shift register, or a collision write that is not discarded, appears as a wrong byte in the receive buffer at the end of the frame. A flag that sets from a control write, or does not stick, appears on the control/status word and on irq in the very next cycle. An error in synchronizer depth shows on the selected bit two cycles after nss_i moves.

// File: rtl/spi_ss_pkg.sv
`timescale 1ns/1ps
package spi_ss_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic done;
    logic wcol;
    logic modf;
    logic ovr;
  } spi_flags_t;

  // sticky update: software mask keeps bits, hardware events set them (set wins)
  function automatic spi_flags_t flag_next(spi_flags_t cur, spi_flags_t keep, spi_flags_t set);
    return spi_flags_t'((cur & keep) | set);
  endfunction

  function automatic logic [7:0] ctrl_word(spi_flags_t f, logic busy, logic sel,
                                           logic mst, logic en);
    return {f.done, f.wcol, f.modf, f.ovr, busy, sel, mst, en};
  endfunction
endpackage

// File: rtl/spi_ss_sync.sv
`timescale 1ns/1ps
module spi_ss_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= INIT[i];
        st2 <= INIT[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/spi_ss_mclk.sv
`timescale 1ns/1ps
module spi_ss_mclk #(
  parameter int DIV   = 4,
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic abort,
  output logic sck,
  output logic rise,
  output logic fall,
  output logic last
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PW   = $clog2(TICKS);

  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic          sck_q;
  logic          tick;

  assign tick = run && !abort && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ph    <= '0;
      sck_q <= 1'b0;
    end else if (!run || abort) begin
      cnt   <= '0;
      ph    <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      ph    <= ph + 1'b1;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sck  = sck_q;
  assign rise = tick & ~sck_q;
  assign fall = tick & sck_q;
  assign last = tick && (ph == PW'(TICKS - 1));
endmodule

// File: rtl/spi_ss_shift.sv
`timescale 1ns/1ps
module spi_ss_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         m_cap,
  input  logic         m_shift,
  input  logic         s_shift,
  input  logic         miso_i,
  input  logic         mosi_s,
  output logic [W-1:0] sh_q,
  output logic [W-1:0] m_word,
  output logic [W-1:0] s_word
);
  logic [W-1:0] sh;
  logic         cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cap <= 1'b0;
    end else begin
      if (load)         sh <= ld_val;
      else if (m_shift) sh <= {sh[W-2:0], cap};
      else if (s_shift) sh <= {sh[W-2:0], mosi_s};
      if (m_cap) cap <= miso_i;
    end
  end

  assign sh_q   = sh;
  assign m_word = {sh[W-2:0], cap};
  assign s_word = {sh[W-2:0], mosi_s};
endmodule

// File: rtl/spi_ss_ctrl.sv
`timescale 1ns/1ps
module spi_ss_ctrl
  import spi_ss_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       nss_i,
  output logic       miso_o
);
  localparam int SCW = $clog2(BYTE_W);

  spi_flags_t        flg;
  logic              busy_q, mst_q, en_q, rx_full, sck_prev;
  logic [BYTE_W-1:0] rx_buf;
  logic [SCW-1:0]    scnt;
  logic [2:0]        pins_s;
  logic              nss_s, sck_s, mosi_s;

  spi_ss_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({nss_i, sck_i, mosi_i}), .q(pins_s)
  );
  assign {nss_s, sck_s, mosi_s} = pins_s;

  // named bus and protocol events
  logic wr_ctrl, wr_data, rd_data, slave_mode, s_rise, s_last, xfer_on;
  logic wcol_ev, m_start, s_load, m_abort, done_ev, ovr_ev, modf_ev;
  logic m_rise, m_fall, m_last;
  logic [BYTE_W-1:0] sh, m_word, s_word, rx_next;

  assign wr_ctrl    = bus_wr & ~bus_sel;
  assign wr_data    = bus_wr & bus_sel;
  assign rd_data    = bus_rd & bus_sel;
  assign slave_mode = en_q & ~mst_q;
  assign s_rise     = slave_mode & ~nss_s & sck_s & ~sck_prev;
  assign s_last     = s_rise && (scnt == SCW'(BYTE_W - 1));
  assign xfer_on    = busy_q | (scnt != '0);
  assign wcol_ev    = wr_data & en_q & xfer_on;
  assign m_start    = wr_data & en_q & mst_q & ~busy_q;
  assign s_load     = wr_data & slave_mode & (scnt == '0);
  assign m_abort    = ~en_q | ~mst_q;
  assign done_ev    = m_last | s_last;
  assign ovr_ev     = done_ev & rx_full;
  assign modf_ev    = en_q & mst_q & ~nss_s;
  assign rx_next    = m_last ? m_word : s_word;

  spi_ss_mclk #(.DIV(CLK_DIV), .TICKS(2 * BYTE_W)) u_mclk (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .abort(m_abort),
    .sck(sck_o), .rise(m_rise), .fall(m_fall), .last(m_last)
  );

  spi_ss_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(m_start | s_load), .ld_val(bus_wdata),
    .m_cap(m_rise), .m_shift(m_fall), .s_shift(s_rise),
    .miso_i(miso_i), .mosi_s(mosi_s), .sh_q(sh), .m_word(m_word), .s_word(s_word)
  );

  spi_flags_t keep, hw_set;
  assign keep   = wr_ctrl ? spi_flags_t'(bus_wdata[7:4]) : spi_flags_t'(4'hF);
  assign hw_set = '{done: done_ev, wcol: wcol_ev, modf: modf_ev, ovr: ovr_ev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg      <= '0;
      mst_q    <= 1'b0;
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      rx_full  <= 1'b0;
      rx_buf   <= '0;
      scnt     <= '0;
      sck_prev <= 1'b0;
    end else begin
      flg      <= flag_next(flg, keep, hw_set);
      sck_prev <= sck_s;
      if (wr_ctrl) {mst_q, en_q} <= bus_wdata[1:0];
      if (m_abort)      busy_q <= 1'b0;
      else if (m_start) busy_q <= 1'b1;
      else if (m_last)  busy_q <= 1'b0;
      if (done_ev && !rx_full) begin
        rx_buf  <= rx_next;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (nss_s || !slave_mode) scnt <= '0;
      else if (s_rise)          scnt <= s_last ? '0 : scnt + 1'b1;
    end
  end

  assign bus_rdata = bus_sel ? rx_buf : ctrl_word(flg, busy_q, ~nss_s, mst_q, en_q);
  assign irq       = |flg;
  assign mosi_o    = sh[BYTE_W-1];
  assign miso_o    = sh[BYTE_W-1];

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_o);                                                   // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flg.done && !(wr_ctrl && !bus_wdata[7]) |=> flg.done);                 // R4
  AST_SW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !done_ev && !flg.done |=> !flg.done);                       // R3
  AST_WCOL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_ev && !m_fall && !s_rise |=> sh == $past(sh));                    // R6
  AST_MODF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    modf_ev |=> flg.modf);                                                 // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg.ovr) |-> $past(rx_full));                                    // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    m_abort |=> !busy_q);                                                  // R12
endmodule

// File: tb/spi_ss_ctrl_test.sv
`timescale 1ns/1ps
module spi_ss_ctrl_test;
  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int FRAME = 8 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       inv = 1'b0, sck_in = 1'b0, mosi_in = 1'b0, nss_in = 1'b1;
  wire  [7:0] rdata;
  wire        irq, sck_o, mosi_o, miso_o;
  wire        miso_in = mosi_o ^ inv;

  spi_ss_ctrl #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wd), .bus_rdata(rdata), .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_in), .sck_i(sck_in), .mosi_i(mosi_in), .nss_i(nss_in), .miso_o(miso_o)
  );

  int compared = 0, mismatched = 0;
  bit chk_on = 0, miso_on = 0;

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // behavioural reference model, one step per rising edge
  bit [3:0] e_fl;  // done, wcol, modf, ovr
  bit e_busy, e_mst, e_en, e_full, e_sck;
  bit [7:0] e_buf, e_tx, e_sh;
  int e_n, e_scnt;
  bit n1, n2, c1, c2, m1, m2, cprev;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_fl = 0; e_busy = 0; e_mst = 0; e_en = 0; e_full = 0; e_sck = 0;
      e_buf = 0; e_tx = 0; e_sh = 0; e_n = 0; e_scnt = 0;
      n1 = 1; n2 = 1; c1 = 0; c2 = 0; m1 = 0; m2 = 0; cprev = 0;
    end else begin
      bit ev_wr, ev_wc, ev_rd, abort, mdone, sdone, srise, set_wcol, start, sload, done_ev;
      bit [7:0] rxv;
      bit [3:0] keep;
      ev_wr = wr && sel; ev_wc = wr && !sel; ev_rd = rd && sel;
      abort    = !e_en || !e_mst;
      set_wcol = ev_wr && e_en && (e_busy || e_scnt != 0);
      start    = ev_wr && e_en && e_mst && !e_busy;
      sload    = ev_wr && e_en && !e_mst && e_scnt == 0;
      srise    = e_en && !e_mst && !n2 && c2 && !cprev;
      sdone    = srise && e_scnt == 7;
      mdone    = 0;
      if (e_busy && !abort) begin
        e_n++;
        mdone = (e_n == FRAME);
      end
      done_ev = mdone || sdone;
      rxv  = mdone ? (e_tx ^ {8{inv}}) : {e_sh[6:0], m2};
      keep = ev_wc ? wd[7:4] : 4'hF;
      e_fl = (e_fl & keep) | {done_ev, set_wcol, e_en && e_mst && !n2, done_ev && e_full};
      if (done_ev && !e_full) begin e_buf = rxv; e_full = 1; end
      else if (ev_rd) e_full = 0;
      if (abort) e_busy = 0;
      else if (start) begin e_busy = 1; e_n = 0; e_tx = wd; end
      else if (mdone) e_busy = 0;
      if (start || sload) e_sh = wd;
      else if (srise) e_sh = {e_sh[6:0], m2};
      if (n2 || !e_en || e_mst) e_scnt = 0;
      else if (srise) e_scnt = (e_scnt == 7) ? 0 : e_scnt + 1;
      if (ev_wc) {e_mst, e_en} = wd[1:0];
      e_sck = e_busy ? ((e_n / HALF) % 2 == 1) : 1'b0;
      cprev = c2; n2 = n1; n1 = nss_in; c2 = c1; c1 = sck_in; m2 = m1; m1 = mosi_in;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      if (!sel) begin
        chk("R4",  {8'd0, rdata[7]}, {8'd0, e_fl[3]}, "done flag");
        chk("R6",  {8'd0, rdata[6]}, {8'd0, e_fl[2]}, "collision flag");
        chk("R7",  {8'd0, rdata[5]}, {8'd0, e_fl[1]}, "mode-fault flag");
        chk("R8",  {8'd0, rdata[4]}, {8'd0, e_fl[0]}, "overrun flag");
        chk("R4",  {8'd0, rdata[3]}, {8'd0, e_busy},  "busy bit");
        chk("R9",  {8'd0, rdata[2]}, {8'd0, !n2},     "selected bit");
        chk("R2",  {7'd0, rdata[1:0]}, {7'd0, e_mst, e_en}, "mode bits");
      end else begin
        chk("R5", {1'b0, rdata}, {1'b0, e_buf}, "receive buffer");
      end
      chk("R11", {8'd0, irq},   {8'd0, |e_fl}, "irq");
      chk("R4",  {8'd0, sck_o}, {8'd0, e_sck}, "sck_o");
      if (miso_on) chk("R10", {8'd0, miso_o}, {8'd0, e_sh[7]}, "miso_o");
    end
  end

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wr = 1'b1; wd = d;
    @(negedge clk); wr = 1'b0; sel = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string tag);
    @(negedge clk); sel = 1'b1; rd = 1'b1;
    #1 chk(tag, {1'b0, rdata}, {1'b0, exp}, "data read");
    @(negedge clk); rd = 1'b0; sel = 1'b0;
  endtask

  task automatic peek(input logic [7:0] exp, input string tag);
    @(negedge clk);
    #1 chk(tag, {1'b0, rdata}, {1'b0, exp}, "control word");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; chk_on = 1;
    @(negedge clk); #1;
    chk("R1", {irq, rdata}, 9'h000, "reset state");
    wr_reg(0, 8'h03);
    peek(8'h03, "R2");
    // master frame with a collision in the middle (R4, R5, R6)
    wr_reg(1, 8'hA5);
    repeat (5) @(negedge clk);
    wr_reg(1, 8'h3C);
    repeat (FRAME) @(negedge clk);
    peek(8'hC3, "R6");
    rd_byte(8'hA5, "R6");
    // clearing write cannot set bits (R3)
    wr_reg(0, 8'hBF);
    peek(8'h83, "R3");
    wr_reg(0, 8'h03);
    peek(8'h03, "R3");
    // overrun (R8): inverted loopback, second frame unread
    inv = 1'b1;
    wr_reg(1, 8'h5A);
    repeat (FRAME + 2) @(negedge clk);
    wr_reg(1, 8'h81);
    repeat (FRAME + 2) @(negedge clk);
    peek(8'h93, "R8");
    chk("R11", {8'd0, irq}, 9'd1, "irq with flags");
    rd_byte(8'hA5, "R8");
    inv = 1'b0;
    wr_reg(0, 8'h03);
    // abort and disabled writes (R12)
    wr_reg(1, 8'hFF);
    repeat (6) @(negedge clk);
    wr_reg(0, 8'h02);
    peek(8'h02, "R12");
    wr_reg(1, 8'h11);
    repeat (FRAME) @(negedge clk);
    peek(8'h02, "R12");
    chk("R12", {8'd0, sck_o}, 9'd0, "sck after abort");
    // mode fault and select mirror (R7, R9)
    wr_reg(0, 8'h03);
    @(negedge clk); nss_in = 1'b0;
    repeat (4) @(negedge clk);
    peek(8'h27, "R7");
    wr_reg(0, 8'h03);
    peek(8'h27, "R3");
    @(negedge clk); nss_in = 1'b1;
    repeat (4) @(negedge clk);
    wr_reg(0, 8'h03);
    peek(8'h03, "R9");
    // slave frame 0x96 with a mid-frame write (R10, R6)
    wr_reg(0, 8'h01);
    wr_reg(1, 8'hC3);
    miso_on = 1;
    #1 chk("R10", {8'd0, miso_o}, 9'd1, "miso after load");
    @(negedge clk); nss_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = 1'((8'h96 >> i) & 8'h01);
      repeat (3) @(negedge clk);
      sck_in = 1'b1;
      repeat (3) @(negedge clk);
      sck_in = 1'b0;
      if (i == 4) wr_reg(1, 8'h00);
    end
    repeat (6) @(negedge clk);
    nss_in = 1'b1;
    repeat (4) @(negedge clk);
    miso_on = 0;
    peek(8'hC1, "R10");
    rd_byte(8'h96, "R10");
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule